// File: doc/BRIEF.md
# Reorder Buffer with In-Line TLB-Miss Handling

This block is the in-order retirement queue of an out-of-order core. Up to two instructions per cycle are written at the tail. Up to two per cycle leave from the head, in program order, once the execution side has marked them complete. Each slot holds the instruction PC and a small set of flags: occupied, complete, exception, TLB-miss and privileged. Execution units, the TLB and register renaming sit outside the block. They report back through a single completion port and a TLB-updated strobe.

An exception is acted on only when the excepting entry reaches the head. For a TLB-miss exception the block first checks whether the free slots can hold the whole miss handler, which has a fixed, known length. If they can, the block does not flush. It records the tail position and the next user fetch PC, enters an in-line mode and redirects fetch to the handler. The handler's instructions then queue up behind the in-flight user work and are tagged privileged. When the last handler instruction has been queued, fetch returns to the recorded PC. When the handler reports that the TLB has been refilled, every entry that missed is re-armed for execution instead of being discarded. If the handler does not fit, or the exception is not a TLB miss, the block flushes, redirects to the handler, and afterwards resumes at the excepting PC.

Top module: `inline_rob`

## Requirements
- R1: After reset the occupancy is 0, mode is user (code 0), no retire lane is valid, no redirect is issued and enqueue is ready.
- R2: Entries retire in program order from the head, at most two per cycle. Lane 0 is the oldest, and lane 1 is valid only when lane 0 is. Retirement stops at the first entry that is not complete or that carries an exception or TLB-miss flag.
- R3: Occupancy is kept as a count of 0 to 16. enq_ready is high only while at least two slots are free. Enqueue requests made while it is low are ignored and leave the occupancy unchanged.
- R4: A TLB-miss exception at the head is handled in-line when the free slots (16 minus occupancy) number at least HANDLER_LEN (6), including exactly 6. This happens two edges after the completion is presented: mode becomes in-line (code 1), a one-cycle redirect to HANDLER_PC is issued and no entry is flushed.
- R5: A head exception that is not a TLB miss, or a TLB miss with fewer free slots than HANDLER_LEN, flushes the buffer to occupancy 0. Mode becomes trap (code 2) and fetch is redirected to HANDLER_PC. After HANDLER_LEN further instructions are enqueued, mode returns to user and a redirect to the excepting PC is issued.
- R6: The first HANDLER_LEN instructions enqueued after entering in-line or trap mode retire with the privileged bit set. User instructions retire with it clear.
- R7: In in-line mode, after the HANDLER_LEN-th handler instruction is enqueued, mode returns to user on that edge. A one-cycle redirect to the fetch_next_pc value sampled when the in-line path was taken is issued at the same time.
- R8: A mispredict reported while in in-line mode replaces the saved resume PC. The redirect at the end of the handler then goes to the corrected target.
- R9: A tlb_updated pulse clears the exception, TLB-miss and complete flags of every TLB-miss entry. Those entries stay in the buffer and retire only after they are completed again.
- R10: While a handler is in progress (in-line or trap mode, or after an in-line entry until tlb_updated), a head exception starts no new handler. It issues no redirect and stalls retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 2 | Enqueue request per lane; lane 1 is used only together with lane 0 |
| enq_pc | input | 64 | Lane k PC at bits [32k+31:32k] |
| fetch_next_pc | input | 32 | PC the fetch unit would fetch next |
| enq_ready | output | 1 | At least two slots free |
| cpl_valid | input | 1 | Completion report |
| cpl_idx | input | 4 | Slot index being completed |
| cpl_exc | input | 1 | Completed instruction raised an exception |
| cpl_tlb_miss | input | 1 | The exception is a TLB miss |
| tlb_updated | input | 1 | Handler has refilled the TLB |
| mispredict | input | 1 | Branch mispredict reported |
| mispredict_pc | input | 32 | Corrected fetch target |
| retire_valid | output | 2 | Lanes retiring at the next edge |
| retire_pc | output | 64 | PC per retiring lane |
| retire_priv | output | 2 | Privileged bit per retiring lane |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | 32 | Redirect target |
| mode_o | output | 2 | 0 user, 1 in-line, 2 trap |
| occupancy | output | 5 | Occupied slots |

## Verification
The retire lanes are combinational on the stored flags. They therefore show a completion one edge after it is presented, and the slot leaves on the following edge. Occupancy, mode and redirect are registered. A head exception is decided one edge after its completion lands, so those outputs change two edges after the completion input. The end-of-handler redirect and the mode change appear one edge after the last handler enqueue. The bench drives every input just after a falling edge and samples outputs at the next falling edge. Checks on a handler decision wait one extra cycle, and checks on draining wait several cycles so that two-per-cycle retirement has settled.

// File: rtl/rob_pkg.sv
// Shared types for the in-line reorder buffer.
// Assumes a two-bit mode code observed at the top-level port.
package rob_pkg;

    typedef enum logic [1:0] {
        MODE_USER   = 2'd0,
        MODE_INLINE = 2'd1,
        MODE_TRAP   = 2'd2
    } rob_mode_e;

    typedef struct packed {
        logic valid;
        logic done;
        logic exc;
        logic tlbm;
        logic priv;
    } rob_flags_t;

endpackage

// File: rtl/rob_entries.sv
// Slot storage: one flag set and one PC per slot.
// Assumes DEPTH and LANES are powers of two, that the controller only
// enqueues into free slots, and that it only retires occupied slots.
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LANES = 2,
    parameter int PC_W  = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int N_W   = $clog2(LANES + 1),
    localparam int LI_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [IDX_W-1:0]      tail,
    input  logic [N_W-1:0]        enq_n,
    input  logic [LANES*PC_W-1:0] enq_pc,
    input  logic [LANES-1:0]      enq_priv,
    input  logic [IDX_W-1:0]      head,
    input  logic [N_W-1:0]        ret_n,
    input  logic                  cpl_valid,
    input  logic [IDX_W-1:0]      cpl_idx,
    input  logic                  cpl_exc,
    input  logic                  cpl_tlbm,
    input  logic                  tlb_clr,
    output rob_flags_t            flags_o [DEPTH],
    output logic [PC_W-1:0]       pcs_o   [DEPTH]
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [IDX_W-1:0] ME = IDX_W'(i);
        rob_flags_t        fl_q;
        logic [PC_W-1:0]   pc_q;
        logic [IDX_W-1:0]  toff;
        logic [IDX_W-1:0]  hoff;
        logic [LI_W-1:0]   lane;

        assign toff = ME - tail;
        assign hoff = ME - head;
        assign lane = toff[LI_W-1:0];

        // Slot flag update: flush, retire, re-arm, complete, then fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fl_q <= '0;
            end else if (flush) begin
                fl_q <= '0;
            end else begin
                if (int'(hoff) < int'(ret_n)) begin
                    fl_q.valid <= 1'b0;
                end
                if (tlb_clr && fl_q.tlbm) begin
                    fl_q.tlbm <= 1'b0;
                    fl_q.exc  <= 1'b0;
                    fl_q.done <= 1'b0;
                end
                if (cpl_valid && cpl_idx == ME && fl_q.valid) begin
                    fl_q.done <= 1'b1;
                    fl_q.exc  <= cpl_exc;
                    fl_q.tlbm <= cpl_exc & cpl_tlbm;
                end
                if (int'(toff) < int'(enq_n)) begin
                    fl_q <= '{valid: 1'b1, done: 1'b0, exc: 1'b0,
                              tlbm: 1'b0, priv: enq_priv[lane]};
                end
            end
        end

        // Slot PC capture on fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q <= '0;
            end else if (!flush && int'(toff) < int'(enq_n)) begin
                pc_q <= enq_pc[lane*PC_W +: PC_W];
            end
        end

        assign flags_o[i] = fl_q;
        assign pcs_o[i]   = pc_q;
    end

endmodule

// File: rtl/rob_retire.sv
// Head evaluation: selects retiring lanes and decides the exception path.
// Assumes the head slot and the following LANES-1 slots are inspected and
// that an exception entry is always marked complete.
module rob_retire
    import rob_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int LANES       = 2,
    parameter int PC_W        = 32,
    parameter int HANDLER_LEN = 6,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int N_W   = $clog2(LANES + 1)
) (
    input  rob_flags_t            flags [DEPTH],
    input  logic [PC_W-1:0]       pcs   [DEPTH],
    input  logic [IDX_W-1:0]      head,
    input  logic [CNT_W-1:0]      count,
    input  rob_mode_e             mode,
    input  logic                  svc_pending,
    input  logic                  tlb_updated,
    output logic [N_W-1:0]        ret_n,
    output logic [LANES-1:0]      ret_valid,
    output logic [LANES*PC_W-1:0] ret_pc,
    output logic [LANES-1:0]      ret_priv,
    output logic                  take_inline,
    output logic                  take_trap,
    output logic [PC_W-1:0]       exc_pc
);

    rob_flags_t       hf;
    logic [CNT_W-1:0] free_slots;
    logic             idle;
    logic             head_exc;

    // Retire lane selection: contiguous run of clean completed entries.
    always_comb begin
        logic [IDX_W-1:0] idx;
        logic             stop;
        stop      = 1'b0;
        ret_n     = '0;
        ret_valid = '0;
        ret_pc    = '0;
        ret_priv  = '0;
        for (int k = 0; k < LANES; k++) begin
            idx = head + IDX_W'(k);
            if (!stop && flags[idx].valid && flags[idx].done &&
                !flags[idx].exc && !flags[idx].tlbm) begin
                ret_valid[k]             = 1'b1;
                ret_pc[k*PC_W +: PC_W]   = pcs[idx];
                ret_priv[k]              = flags[idx].priv;
                ret_n                    = ret_n + N_W'(1);
            end else begin
                stop = 1'b1;
            end
        end
    end

    // Exception path decision for the head entry.
    always_comb begin
        hf          = flags[head];
        free_slots  = CNT_W'(DEPTH) - count;
        idle        = (mode == MODE_USER) && !svc_pending && !tlb_updated;
        head_exc    = hf.valid && hf.done && hf.exc;
        take_inline = idle && head_exc && hf.tlbm &&
                      (int'(free_slots) >= HANDLER_LEN);
        take_trap   = idle && head_exc && !take_inline;
        exc_pc      = pcs[head];
    end

endmodule

// File: rtl/rob_ctrl.sv
// Pointer, occupancy and mode control with the fetch redirect register.
// Assumes HANDLER_LEN <= DEPTH - LANES and that enqueue lanes are filled
// from lane 0 upward.
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int              DEPTH       = 16,
    parameter int              LANES       = 2,
    parameter int              PC_W        = 32,
    parameter int              HANDLER_LEN = 6,
    parameter logic [PC_W-1:0] HANDLER_PC  = '0,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int N_W   = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] enq_valid,
    input  logic [PC_W-1:0]  fetch_next_pc,
    input  logic             mispredict,
    input  logic [PC_W-1:0]  mispredict_pc,
    input  logic             tlb_updated,
    input  logic [N_W-1:0]   ret_n,
    input  logic             take_inline,
    input  logic             take_trap,
    input  logic [PC_W-1:0]  exc_pc,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output rob_mode_e        mode,
    output logic             svc_pending,
    output logic             flush,
    output logic [N_W-1:0]   enq_n,
    output logic [LANES-1:0] enq_priv,
    output logic             enq_ready,
    output logic             redirect_valid,
    output logic [PC_W-1:0]  redirect_pc
);

    logic [PC_W-1:0]  saved_pc;
    logic [IDX_W-1:0] hbase;
    logic [N_W-1:0]   req_n;
    logic [IDX_W-1:0] hcnt_next;
    logic             hdone;

    // Enqueue acceptance, handler tagging and handler-complete detection.
    always_comb begin
        logic             brk;
        logic [IDX_W-1:0] off;
        enq_ready = (count <= CNT_W'(DEPTH - LANES));
        flush     = take_trap;
        brk       = 1'b0;
        req_n     = '0;
        for (int k = 0; k < LANES; k++) begin
            if (enq_valid[k] && !brk) begin
                req_n = req_n + N_W'(1);
            end else begin
                brk = 1'b1;
            end
        end
        enq_n = (enq_ready && !flush) ? req_n : '0;
        for (int k = 0; k < LANES; k++) begin
            off         = tail + IDX_W'(k) - hbase;
            enq_priv[k] = (mode != MODE_USER) && (int'(off) < HANDLER_LEN);
        end
        hcnt_next = tail + IDX_W'(enq_n) - hbase;
        hdone     = (mode != MODE_USER) && (int'(hcnt_next) >= HANDLER_LEN);
    end

    // State update: pointers, occupancy, mode, saved PC and redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head           <= '0;
            tail           <= '0;
            count          <= '0;
            mode           <= MODE_USER;
            svc_pending    <= 1'b0;
            saved_pc       <= '0;
            hbase          <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= 1'b0;
            if (tlb_updated) begin
                svc_pending <= 1'b0;
            end
            if (take_trap) begin
                head           <= '0;
                tail           <= '0;
                count          <= '0;
                mode           <= MODE_TRAP;
                saved_pc       <= exc_pc;
                hbase          <= '0;
                redirect_valid <= 1'b1;
                redirect_pc    <= HANDLER_PC;
            end else begin
                head  <= head + IDX_W'(ret_n);
                tail  <= tail + IDX_W'(enq_n);
                count <= count - CNT_W'(ret_n) + CNT_W'(enq_n);
                if (take_inline) begin
                    mode           <= MODE_INLINE;
                    svc_pending    <= 1'b1;
                    saved_pc       <= fetch_next_pc;
                    hbase          <= tail + IDX_W'(enq_n);
                    redirect_valid <= 1'b1;
                    redirect_pc    <= HANDLER_PC;
                end else if (hdone) begin
                    mode           <= MODE_USER;
                    redirect_valid <= 1'b1;
                    redirect_pc    <= (mispredict && mode == MODE_INLINE)
                                      ? mispredict_pc : saved_pc;
                end else if (mispredict && mode == MODE_INLINE) begin
                    saved_pc <= mispredict_pc;
                end
            end
        end
    end

endmodule

// File: rtl/inline_rob.sv
// Top level: circular reorder buffer that runs short exception handlers
// in-line when they fit, and flushes otherwise.
// Assumes execution, TLB and renaming are external and report through
// the completion port and the TLB-updated strobe.
module inline_rob
    import rob_pkg::*;
#(
    parameter int              DEPTH       = 16,
    parameter int              LANES       = 2,
    parameter int              PC_W        = 32,
    parameter int              HANDLER_LEN = 6,
    parameter logic [PC_W-1:0] HANDLER_PC  = 32'h0000_0080,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int N_W   = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0]      enq_valid,
    input  logic [LANES*PC_W-1:0] enq_pc,
    input  logic [PC_W-1:0]       fetch_next_pc,
    output logic                  enq_ready,
    input  logic                  cpl_valid,
    input  logic [IDX_W-1:0]      cpl_idx,
    input  logic                  cpl_exc,
    input  logic                  cpl_tlb_miss,
    input  logic                  tlb_updated,
    input  logic                  mispredict,
    input  logic [PC_W-1:0]       mispredict_pc,
    output logic [LANES-1:0]      retire_valid,
    output logic [LANES*PC_W-1:0] retire_pc,
    output logic [LANES-1:0]      retire_priv,
    output logic                  redirect_valid,
    output logic [PC_W-1:0]       redirect_pc,
    output logic [1:0]            mode_o,
    output logic [CNT_W-1:0]      occupancy
);

    rob_flags_t       flags [DEPTH];
    logic [PC_W-1:0]  pcs   [DEPTH];
    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic [CNT_W-1:0] count;
    rob_mode_e        mode;
    logic             svc_pending;
    logic             flush;
    logic [N_W-1:0]   enq_n;
    logic [LANES-1:0] enq_priv;
    logic [N_W-1:0]   ret_n;
    logic             take_inline;
    logic             take_trap;
    logic [PC_W-1:0]  exc_pc;

    rob_entries #(.DEPTH(DEPTH), .LANES(LANES), .PC_W(PC_W)) u_entries (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .tail     (tail),
        .enq_n    (enq_n),
        .enq_pc   (enq_pc),
        .enq_priv (enq_priv),
        .head     (head),
        .ret_n    (ret_n),
        .cpl_valid(cpl_valid),
        .cpl_idx  (cpl_idx),
        .cpl_exc  (cpl_exc),
        .cpl_tlbm (cpl_tlb_miss),
        .tlb_clr  (tlb_updated),
        .flags_o  (flags),
        .pcs_o    (pcs)
    );

    rob_retire #(.DEPTH(DEPTH), .LANES(LANES), .PC_W(PC_W),
                 .HANDLER_LEN(HANDLER_LEN)) u_retire (
        .flags      (flags),
        .pcs        (pcs),
        .head       (head),
        .count      (count),
        .mode       (mode),
        .svc_pending(svc_pending),
        .tlb_updated(tlb_updated),
        .ret_n      (ret_n),
        .ret_valid  (retire_valid),
        .ret_pc     (retire_pc),
        .ret_priv   (retire_priv),
        .take_inline(take_inline),
        .take_trap  (take_trap),
        .exc_pc     (exc_pc)
    );

    rob_ctrl #(.DEPTH(DEPTH), .LANES(LANES), .PC_W(PC_W),
               .HANDLER_LEN(HANDLER_LEN), .HANDLER_PC(HANDLER_PC)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .enq_valid     (enq_valid),
        .fetch_next_pc (fetch_next_pc),
        .mispredict    (mispredict),
        .mispredict_pc (mispredict_pc),
        .tlb_updated   (tlb_updated),
        .ret_n         (ret_n),
        .take_inline   (take_inline),
        .take_trap     (take_trap),
        .exc_pc        (exc_pc),
        .head          (head),
        .tail          (tail),
        .count         (count),
        .mode          (mode),
        .svc_pending   (svc_pending),
        .flush         (flush),
        .enq_n         (enq_n),
        .enq_priv      (enq_priv),
        .enq_ready     (enq_ready),
        .redirect_valid(redirect_valid),
        .redirect_pc   (redirect_pc)
    );

    assign mode_o    = mode;
    assign occupancy = count;

endmodule

// File: rtl/inline_rob_chk.sv
// Property checker for inline_rob, attached by bind.
// Assumes only top-level ports are observed.
module inline_rob_chk
    import rob_pkg::*;
#(
    parameter int              DEPTH      = 16,
    parameter int              LANES      = 2,
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = '0,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] occupancy,
    input logic [1:0]       mode_o,
    input logic [LANES-1:0] retire_valid,
    input logic             redirect_valid,
    input logic [PC_W-1:0]  redirect_pc
);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH);

    assert_retire_contig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid & (retire_valid + 1'b1)) == '0);

    assert_inline_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_o == MODE_INLINE) |-> (redirect_valid && redirect_pc == HANDLER_PC));

    assert_trap_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_o == MODE_TRAP) |-> (occupancy == '0 && redirect_valid));

    assert_inline_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_o == MODE_INLINE) |-> redirect_valid);

    assert_no_nest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_INLINE) |=> (mode_o != MODE_TRAP));

endmodule

bind inline_rob inline_rob_chk #(
    .DEPTH(DEPTH), .LANES(LANES), .PC_W(PC_W), .HANDLER_PC(HANDLER_PC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .occupancy     (occupancy),
    .mode_o        (mode_o),
    .retire_valid  (retire_valid),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc)
);

// File: tb/inline_rob_bench.sv
// Self-checking bench for inline_rob: a retirement-pattern table walked by
// one loop, then directed runs for reset, full buffer and both exception paths.
module inline_rob_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] HPC        = 32'h0000_0080;

    // mask[3:0] of completed entries, expected retire lanes, expected occupancy
    localparam logic [8:0] VEC [6] = '{
        {4'b1111, 2'b11, 3'd0},
        {4'b0111, 2'b11, 3'd1},
        {4'b0001, 2'b01, 3'd3},
        {4'b1110, 2'b00, 3'd4},
        {4'b1101, 2'b01, 3'd3},
        {4'b0011, 2'b11, 3'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  enq_valid = '0;
    logic [63:0] enq_pc = '0;
    logic [31:0] fetch_next_pc = '0;
    logic        enq_ready;
    logic        cpl_valid = 1'b0;
    logic [3:0]  cpl_idx = '0;
    logic        cpl_exc = 1'b0;
    logic        cpl_tlb_miss = 1'b0;
    logic        tlb_updated = 1'b0;
    logic        mispredict = 1'b0;
    logic [31:0] mispredict_pc = '0;
    logic [1:0]  retire_valid;
    logic [63:0] retire_pc;
    logic [1:0]  retire_priv;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [1:0]  mode_o;
    logic [4:0]  occupancy;

    int total = 0;
    int bad = 0;
    int priv_cnt = 0;
    int user_cnt = 0;
    logic [3:0] bt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inline_rob u_inline_rob (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_pc(enq_pc),
        .fetch_next_pc(fetch_next_pc), .enq_ready(enq_ready),
        .cpl_valid(cpl_valid), .cpl_idx(cpl_idx), .cpl_exc(cpl_exc),
        .cpl_tlb_miss(cpl_tlb_miss), .tlb_updated(tlb_updated),
        .mispredict(mispredict), .mispredict_pc(mispredict_pc),
        .retire_valid(retire_valid), .retire_pc(retire_pc),
        .retire_priv(retire_priv), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .mode_o(mode_o), .occupancy(occupancy)
    );

    // Retirement monitor: tallies privileged and user retirements.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                if (retire_valid[k]) begin
                    if (retire_priv[k]) priv_cnt++;
                    else user_cnt++;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic enq(input int n, input logic [31:0] pc0);
        enq_valid = (n == 2) ? 2'b11 : ((n == 1) ? 2'b01 : 2'b00);
        enq_pc    = {pc0 + 32'd4, pc0};
        cyc();
        enq_valid = '0;
        bt        = bt + 4'(n);
    endtask

    task automatic cpl(input logic [3:0] idx, input logic exc, input logic tlbm);
        cpl_valid    = 1'b1;
        cpl_idx      = idx;
        cpl_exc      = exc;
        cpl_tlb_miss = tlbm;
        cyc();
        cpl_valid    = 1'b0;
        cpl_exc      = 1'b0;
        cpl_tlb_miss = 1'b0;
    endtask

    task automatic pulse_tlb();
        tlb_updated = 1'b1;
        cyc();
        tlb_updated = 1'b0;
    endtask

    task automatic finish_bench();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_bench();
    end

    initial begin
        logic [3:0] base;
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 occupancy", 64'(occupancy), 64'd0);
        chk("R1 mode", 64'(mode_o), 64'd0);
        chk("R1 retire", 64'(retire_valid), 64'd0);
        chk("R1 redirect", 64'(redirect_valid), 64'd0);
        chk("R1 ready", 64'(enq_ready), 64'd1);

        // R2: retirement patterns from the table
        for (int v = 0; v < 6; v++) begin
            logic [3:0] m;
            m = VEC[v][8:5];
            base = bt;
            enq(2, 32'h0000_1000);
            enq(2, 32'h0000_1008);
            for (int b = 3; b >= 0; b--) begin
                if (m[b]) cpl(base + 4'(b), 1'b0, 1'b0);
            end
            chk("R2 retire lanes", 64'(retire_valid), 64'(VEC[v][4:3]));
            repeat (3) cyc();
            chk("R2 stop at incomplete", 64'(occupancy), 64'(VEC[v][2:0]));
            for (int b = 0; b < 4; b++) begin
                if (!m[b]) cpl(base + 4'(b), 1'b0, 1'b0);
            end
            repeat (4) cyc();
            chk("R2 drained", 64'(occupancy), 64'd0);
        end

        // R3: fill to 16, enqueue ignored while not ready
        base = bt;
        for (int k = 0; k < 7; k++) enq(2, 32'h0000_2000 + 32'(8 * k));
        chk("R3 ready at 14", 64'(enq_ready), 64'd1);
        enq(2, 32'h0000_2038);
        chk("R3 occupancy 16", 64'(occupancy), 64'd16);
        chk("R3 not ready", 64'(enq_ready), 64'd0);
        enq_valid = 2'b11;
        enq_pc    = {32'hDEAD_0004, 32'hDEAD_0000};
        cyc();
        enq_valid = '0;
        chk("R3 ignored when full", 64'(occupancy), 64'd16);
        cpl(base, 1'b0, 1'b0);
        chk("R2 oldest in lane 0", 64'(retire_pc[31:0]), 64'h2000);
        chk("R2 single lane", 64'(retire_valid), 64'b01);
        for (int k = 1; k < 16; k++) cpl(base + 4'(k), 1'b0, 1'b0);
        repeat (4) cyc();
        chk("R2 full drain", 64'(occupancy), 64'd0);

        // Inline run with exactly HANDLER_LEN free slots
        base = bt;
        priv_cnt = 0;
        user_cnt = 0;
        for (int k = 0; k < 5; k++) enq(2, 32'h0000_3000 + 32'(8 * k));
        fetch_next_pc = 32'h0000_3800;
        cpl(base + 4'd2, 1'b1, 1'b1);
        cpl(base, 1'b1, 1'b1);
        cyc();
        chk("R4 mode inline", 64'(mode_o), 64'd1);
        chk("R4 redirect", 64'(redirect_valid), 64'd1);
        chk("R4 redirect pc", 64'(redirect_pc), 64'(HPC));
        chk("R4 no flush", 64'(occupancy), 64'd10);
        cyc();
        chk("R4 redirect one cycle", 64'(redirect_valid), 64'd0);
        chk("R10 head stalled", 64'(retire_valid), 64'd0);
        fetch_next_pc = 32'h0000_9999;
        enq(2, HPC);
        enq(2, HPC + 32'd8);
        enq(2, HPC + 32'd16);
        chk("R7 mode user", 64'(mode_o), 64'd0);
        chk("R7 redirect", 64'(redirect_valid), 64'd1);
        chk("R7 resume pc", 64'(redirect_pc), 64'h3800);
        chk("R7 occupancy", 64'(occupancy), 64'd16);
        repeat (2) cyc();
        chk("R10 no new handler", 64'(mode_o), 64'd0);
        chk("R10 no redirect", 64'(redirect_valid), 64'd0);
        chk("R10 retire stalled", 64'(retire_valid), 64'd0);
        pulse_tlb();
        chk("R9 kept", 64'(occupancy), 64'd16);
        chk("R9 head re-armed", 64'(retire_valid), 64'd0);
        cpl(base, 1'b0, 1'b0);
        cpl(base + 4'd1, 1'b0, 1'b0);
        repeat (3) cyc();
        chk("R9 second miss re-armed", 64'(occupancy), 64'd14);
        for (int k = 2; k < 16; k++) cpl(base + 4'(k), 1'b0, 1'b0);
        repeat (6) cyc();
        chk("R9 drained", 64'(occupancy), 64'd0);
        chk("R6 privileged count", 64'(priv_cnt), 64'd6);
        chk("R6 user count", 64'(user_cnt), 64'd10);

        // Inline run with mispredict during the handler
        base = bt;
        for (int k = 0; k < 2; k++) enq(2, 32'h0000_4000 + 32'(8 * k));
        fetch_next_pc = 32'h0000_4100;
        cpl(base, 1'b1, 1'b1);
        cyc();
        chk("R4 inline with room", 64'(mode_o), 64'd1);
        mispredict    = 1'b1;
        mispredict_pc = 32'h0000_4400;
        enq(2, HPC);
        mispredict    = 1'b0;
        enq(2, HPC + 32'd8);
        enq(2, HPC + 32'd16);
        chk("R8 corrected resume", 64'(redirect_pc), 64'h4400);
        pulse_tlb();
        for (int k = 0; k < 10; k++) cpl(base + 4'(k), 1'b0, 1'b0);
        repeat (4) cyc();
        chk("R8 drained", 64'(occupancy), 64'd0);

        // R5: too little room, conventional path
        base = bt;
        for (int k = 0; k < 6; k++) enq(2, 32'h0000_5000 + 32'(8 * k));
        cpl(base, 1'b1, 1'b1);
        cyc();
        chk("R5 flushed", 64'(occupancy), 64'd0);
        chk("R5 mode trap", 64'(mode_o), 64'd2);
        chk("R5 redirect pc", 64'(redirect_pc), 64'(HPC));
        bt = '0;
        priv_cnt = 0;
        user_cnt = 0;
        enq(2, HPC);
        enq(2, HPC + 32'd8);
        enq(2, HPC + 32'd16);
        chk("R5 mode back", 64'(mode_o), 64'd0);
        chk("R5 resume at excepting pc", 64'(redirect_pc), 64'h5000);
        for (int k = 0; k < 6; k++) cpl(4'(k), 1'b0, 1'b0);
        repeat (4) cyc();
        chk("R6 trap handler privileged", 64'(priv_cnt), 64'd6);

        // R5: non-TLB exception with room still flushes
        base = bt;
        enq(2, 32'h0000_6000);
        cpl(base, 1'b1, 1'b0);
        cyc();
        chk("R5 non-miss trap", 64'(mode_o), 64'd2);
        chk("R5 non-miss flush", 64'(occupancy), 64'd0);
        bt = '0;
        enq(2, HPC);
        enq(2, HPC + 32'd8);
        enq(2, HPC + 32'd16);
        chk("R5 non-miss resume", 64'(redirect_pc), 64'h6000);
        for (int k = 0; k < 6; k++) cpl(4'(k), 1'b0, 1'b0);
        repeat (4) cyc();
        chk("R5 final drain", 64'(occupancy), 64'd0);

        finish_bench();
    end

endmodule